// File: doc/BRIEF.md
# Handset Power Mode Controller

This block holds the power state of a handset application processor and drives the enables that go with that state. There are four modes: full-speed operation, a light standby with the core clock gated, a deep standby running from the slow always-on clock, and a stopped state. Software asks for a lower mode through a one-cycle request port. Wake events bring the block back to full-speed operation: touch, timer, key, incoming call, or a debounced short press of the power key. Which events count depends on the current mode.

Each mode change steps the outputs through a fixed order, one group per step. Going down, the order is backlights, then supplies, then clock. Waking runs in the reverse order. The clock step of a wake holds until the clock generator reports a stable clock. The radio modem keeps its supply in every mode except the stopped one. The stopped mode is left only through reset.

The block only selects and gates clocks; it does not generate them. Regulators, dimming and the register bus are outside it.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While reset is asserted, and once it is released, the block is in full-speed mode. All enables are high, the fast clock is selected, mode_status is 0, and both req_ack and req_err are low.
- R2: Mode codes are 0 full-speed, 1 light standby, 2 deep standby and 3 stopped. In each settled mode the outputs are as follows.
  - Code 0: every enable high and the fast clock selected.
  - Code 1: core clock gated, backlights off, peripheral and modem supplies on, fast clock selected.
  - Code 2: slow clock selected, core gated, backlights and peripheral supply off, modem supply on.
  - Code 3: slow clock selected and every enable low.
- R3: Only four requests are accepted: 0 to 1, 0 to 2, 0 to 3 and 1 to 2. For an accepted request sampled at edge E, the changes come in three steps.
  - At E the backlights change.
  - At E+1 the supply enables change.
  - At E+2 the clock outputs and mode_status change, and req_ack is high for that one cycle.
- R4: Any other request leaves every output except the acknowledge and error unchanged. It raises req_ack for one cycle after the sampling edge and sets req_err. req_err then stays set until reset.
- R5: In mode 1, a high level on wake_touch, wake_timer, wake_key or wake_call at edge W starts a wake.
  - At W the core clock turns on.
  - At W+1 the supplies come back.
  - At W+2 the backlights come on and mode_status becomes 0.
- R6: In mode 2, only a short power-key press starts a wake. The other four wake inputs have no effect in that mode.
- R7: A power-key press counts as short when it is held for at least KEY_MIN_CYC and at most KEY_MAX_CYC clock cycles after a two-stage synchronizer. A press shorter or longer than that does nothing. The wake begins four edges after the key input is released.
- R8: During a wake, the step after the clock switch waits for clk_stable to be high. While clk_stable is low, the supplies and backlights stay as they were.
- R9: In mode 3, no wake input, power-key press or request changes the mode. Requests there are rejected as in R4, and only reset returns the block to mode 0.
- R10: modem_pwr_en stays high in every mode and every transition step, except for the steps of entering mode 3 and mode 3 itself.
- R11: When a valid wake and a request arrive in the same cycle, the wake runs. The request is dropped with no req_ack and no change to req_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | One-cycle request for a mode change |
| req_mode | input | 2 | Requested mode code |
| req_ack | output | 1 | One-cycle pulse: request completed or rejected |
| req_err | output | 1 | Sticky flag for a rejected request |
| wake_touch | input | 1 | Touch-screen wake level |
| wake_timer | input | 1 | Timer wake level |
| wake_key | input | 1 | Keypad wake level |
| wake_call | input | 1 | Incoming-call wake level |
| pwr_key | input | 1 | Raw power key, asynchronous |
| clk_stable | input | 1 | Clock generator reports the selected clock is stable |
| clk_sel_slow | output | 1 | Selects the slow always-on clock |
| core_clk_en | output | 1 | Core clock gate enable |
| kbd_bl_en | output | 1 | Keypad backlight enable |
| lcd_bl_en | output | 1 | Display backlight enable |
| periph_pwr_en | output | 1 | Peripheral supply enable |
| modem_pwr_en | output | 1 | Modem supply enable |
| mode_status | output | 2 | Current settled mode code |

## Verification
The bound checker watches the orderings on every cycle. Supplies never drop while a backlight is lit, and the slow clock is never chosen while supplies are up. A backlight only turns on with supplies present and the fast clock selected, and the core clock is never enabled on the slow clock. The checker also covers the modem supply outside the stopped mode, the permanence of the stopped mode and of the error flag, and the fact that deep standby only exits to full speed. The exact step timing, the per-mode wake masks, the press-length window, the clock-stable stall and the wake-over-request priority need the stimulus and per-cycle expectations that only the bench scenarios supply.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [1:0] {
    PM_NORMAL = 2'd0,
    PM_IDLE   = 2'd1,
    PM_SLEEP  = 2'd2,
    PM_OFF    = 2'd3
  } pm_mode_e;

  typedef enum logic [2:0] {
    PH_STABLE,
    PH_DN_PERIPH,
    PH_DN_CLOCK,
    PH_UP_WAIT,
    PH_UP_LIGHTS
  } pm_phase_e;

  // wake source bit positions
  localparam int unsigned WAKE_SRCS = 5;
  localparam int unsigned WK_TOUCH  = 0;
  localparam int unsigned WK_TIMER  = 1;
  localparam int unsigned WK_KEY    = 2;
  localparam int unsigned WK_CALL   = 3;
  localparam int unsigned WK_PWRKEY = 4;

  function automatic logic entry_legal(pm_mode_e cur, pm_mode_e tgt);
    logic ok;
    ok = 1'b0;
    case (cur)
      PM_NORMAL: ok = (tgt != PM_NORMAL);
      PM_IDLE:   ok = (tgt == PM_SLEEP);
      default:   ok = 1'b0;
    endcase
    return ok;
  endfunction

  function automatic logic [WAKE_SRCS-1:0] wake_mask(pm_mode_e m);
    logic [WAKE_SRCS-1:0] msk;
    msk = '0;
    case (m)
      PM_IDLE: begin
        msk[WK_TOUCH] = 1'b1;
        msk[WK_TIMER] = 1'b1;
        msk[WK_KEY]   = 1'b1;
        msk[WK_CALL]  = 1'b1;
      end
      PM_SLEEP: msk[WK_PWRKEY] = 1'b1;
      default:  msk = '0;
    endcase
    return msk;
  endfunction

endpackage

// File: rtl/pm_key_filter.sv
module pm_key_filter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MIN_CYC     = 4,
  parameter int unsigned MAX_CYC     = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic key_raw,
  output logic short_press
);
  localparam int unsigned CNT_W = $clog2(MAX_CYC + 2);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LO  = CNT_W'(MIN_CYC);
  localparam logic [CNT_W-1:0] CNT_HI  = CNT_W'(MAX_CYC);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   key_lvl;
  logic [CNT_W-1:0]       cnt_q, cnt_d;
  logic                   press_q, press_d;

  assign key_lvl = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= (sync_q << 1) | SYNC_STAGES'(key_raw);
  end

  always_comb begin
    cnt_d   = cnt_q;
    press_d = 1'b0;
    if (key_lvl) begin
      if (cnt_q != CNT_SAT) cnt_d = cnt_q + 1'b1;
    end else begin
      cnt_d   = '0;
      press_d = (cnt_q >= CNT_LO) && (cnt_q <= CNT_HI);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      press_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      press_q <= press_d;
    end
  end

  assign short_press = press_q;
endmodule

// File: rtl/pm_wake_sel.sv
module pm_wake_sel
  import pwr_mode_pkg::*;
#(
  parameter int unsigned NSRC = WAKE_SRCS
) (
  input  logic [NSRC-1:0] src,
  input  pm_mode_e        mode,
  output logic            hit
);
  logic [WAKE_SRCS-1:0] msk;
  logic [NSRC-1:0]      gated;

  assign msk = wake_mask(mode);

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign gated[g] = src[g] & msk[g];
  end

  assign hit = |gated;
endmodule

// File: rtl/pm_sequencer.sv
module pm_sequencer
  import pwr_mode_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req_valid,
  input  pm_mode_e req_mode,
  input  logic     wake_hit,
  input  logic     clk_stable,
  output pm_mode_e cur_mode,
  output pm_mode_e bl_mode,
  output pm_mode_e per_mode,
  output pm_mode_e clk_mode,
  output logic     ack,
  output logic     err,
  output logic     busy
);
  pm_phase_e phase_q, phase_d;
  pm_mode_e  cur_q, cur_d, tgt_q, tgt_d;
  pm_mode_e  bl_q, bl_d, per_q, per_d, clk_q, clk_d;
  logic      ack_q, ack_d, err_q, err_d;
  logic      step_en;

  assign step_en = (phase_q != PH_STABLE) || wake_hit || req_valid;

  always_comb begin
    phase_d = phase_q;
    cur_d   = cur_q;
    tgt_d   = tgt_q;
    bl_d    = bl_q;
    per_d   = per_q;
    clk_d   = clk_q;
    ack_d   = 1'b0;
    err_d   = err_q;
    case (phase_q)
      PH_STABLE: begin
        if (wake_hit) begin
          clk_d   = PM_NORMAL;
          phase_d = PH_UP_WAIT;
        end else if (req_valid) begin
          if (entry_legal(cur_q, req_mode)) begin
            tgt_d   = req_mode;
            bl_d    = req_mode;
            phase_d = PH_DN_PERIPH;
          end else begin
            ack_d = 1'b1;
            err_d = 1'b1;
          end
        end
      end
      PH_DN_PERIPH: begin
        per_d   = tgt_q;
        phase_d = PH_DN_CLOCK;
      end
      PH_DN_CLOCK: begin
        clk_d   = tgt_q;
        cur_d   = tgt_q;
        ack_d   = 1'b1;
        phase_d = PH_STABLE;
      end
      PH_UP_WAIT: begin
        if (clk_stable) begin
          per_d   = PM_NORMAL;
          phase_d = PH_UP_LIGHTS;
        end
      end
      PH_UP_LIGHTS: begin
        bl_d    = PM_NORMAL;
        cur_d   = PM_NORMAL;
        phase_d = PH_STABLE;
      end
      default: phase_d = PH_STABLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_STABLE;
      cur_q   <= PM_NORMAL;
      tgt_q   <= PM_NORMAL;
      bl_q    <= PM_NORMAL;
      per_q   <= PM_NORMAL;
      clk_q   <= PM_NORMAL;
      err_q   <= 1'b0;
    end else if (step_en) begin
      phase_q <= phase_d;
      cur_q   <= cur_d;
      tgt_q   <= tgt_d;
      bl_q    <= bl_d;
      per_q   <= per_d;
      clk_q   <= clk_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= ack_d;
  end

  assign cur_mode = cur_q;
  assign bl_mode  = bl_q;
  assign per_mode = per_q;
  assign clk_mode = clk_q;
  assign ack      = ack_q;
  assign err      = err_q;
  assign busy     = (phase_q != PH_STABLE);
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int unsigned RST_SYNC_STAGES = 2,
  parameter int unsigned KEY_SYNC_STAGES = 2,
  parameter int unsigned KEY_MIN_CYC     = 4,
  parameter int unsigned KEY_MAX_CYC     = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] req_mode,
  output logic       req_ack,
  output logic       req_err,
  input  logic       wake_touch,
  input  logic       wake_timer,
  input  logic       wake_key,
  input  logic       wake_call,
  input  logic       pwr_key,
  input  logic       clk_stable,
  output logic       clk_sel_slow,
  output logic       core_clk_en,
  output logic       kbd_bl_en,
  output logic       lcd_bl_en,
  output logic       periph_pwr_en,
  output logic       modem_pwr_en,
  output logic [1:0] mode_status
);
  logic [RST_SYNC_STAGES-1:0] rst_pipe;
  logic                       rst_int_n;
  logic                       key_press;
  logic [WAKE_SRCS-1:0]       wake_src;
  logic                       wake_hit;
  logic                       seq_busy;
  pm_mode_e                   cur_mode, bl_mode, per_mode, clk_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= (rst_pipe << 1) | RST_SYNC_STAGES'(1);
  end
  assign rst_int_n = rst_pipe[RST_SYNC_STAGES-1];

  pm_key_filter #(
    .SYNC_STAGES (KEY_SYNC_STAGES),
    .MIN_CYC     (KEY_MIN_CYC),
    .MAX_CYC     (KEY_MAX_CYC)
  ) u_key (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .key_raw     (pwr_key),
    .short_press (key_press)
  );

  always_comb begin
    wake_src            = '0;
    wake_src[WK_TOUCH]  = wake_touch;
    wake_src[WK_TIMER]  = wake_timer;
    wake_src[WK_KEY]    = wake_key;
    wake_src[WK_CALL]   = wake_call;
    wake_src[WK_PWRKEY] = key_press;
  end

  pm_wake_sel #(.NSRC(WAKE_SRCS)) u_wake (
    .src  (wake_src),
    .mode (cur_mode),
    .hit  (wake_hit)
  );

  pm_sequencer u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .req_valid  (req_valid),
    .req_mode   (pm_mode_e'(req_mode)),
    .wake_hit   (wake_hit),
    .clk_stable (clk_stable),
    .cur_mode   (cur_mode),
    .bl_mode    (bl_mode),
    .per_mode   (per_mode),
    .clk_mode   (clk_mode),
    .ack        (req_ack),
    .err        (req_err),
    .busy       (seq_busy)
  );

  always_comb begin
    lcd_bl_en     = (bl_mode == PM_NORMAL);
    kbd_bl_en     = (bl_mode == PM_NORMAL);
    periph_pwr_en = (per_mode == PM_NORMAL) || (per_mode == PM_IDLE);
    modem_pwr_en  = (per_mode != PM_OFF);
    core_clk_en   = (clk_mode == PM_NORMAL);
    clk_sel_slow  = (clk_mode == PM_SLEEP) || (clk_mode == PM_OFF);
  end

  assign mode_status = cur_mode;
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       seq_busy,
  input logic       req_err,
  input logic       clk_sel_slow,
  input logic       core_clk_en,
  input logic       kbd_bl_en,
  input logic       lcd_bl_en,
  input logic       periph_pwr_en,
  input logic       modem_pwr_en,
  input logic [1:0] mode_status
);
  p_modem_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_busy && mode_status != 2'd3) |-> modem_pwr_en);

  p_off_final_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_status == 2'd3) |=> (mode_status == 2'd3));

  p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |=> req_err);

  p_lights_before_supply_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(periph_pwr_en) |-> (!lcd_bl_en && !kbd_bl_en));

  p_supply_before_slow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_sel_slow) |-> !periph_pwr_en);

  p_lights_last_on_wake_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcd_bl_en) |-> (periph_pwr_en && !clk_sel_slow));

  p_core_on_fast_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    core_clk_en |-> !clk_sel_slow);

  p_idle_from_normal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(mode_status) && mode_status == 2'd1) |-> ($past(mode_status) == 2'd0));

  p_sleep_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(mode_status) && $past(mode_status) == 2'd2) |-> (mode_status == 2'd0));
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .seq_busy      (seq_busy),
  .req_err       (req_err),
  .clk_sel_slow  (clk_sel_slow),
  .core_clk_en   (core_clk_en),
  .kbd_bl_en     (kbd_bl_en),
  .lcd_bl_en     (lcd_bl_en),
  .periph_pwr_en (periph_pwr_en),
  .modem_pwr_en  (modem_pwr_en),
  .mode_status   (mode_status)
);

// File: tb/pwr_mode_ctrl_bench.sv
module pwr_mode_ctrl_bench;
  localparam int MN = 0, MI = 1, MS = 2, MO = 3;

  logic clk = 1'b0;
  logic rst_n, req_valid, wake_touch, wake_timer, wake_key, wake_call, pwr_key, clk_stable;
  logic [1:0] req_mode;
  logic req_ack, req_err, clk_sel_slow, core_clk_en, kbd_bl_en, lcd_bl_en;
  logic periph_pwr_en, modem_pwr_en;
  logic [1:0] mode_status;

  always #2 clk = ~clk;

  pwr_mode_ctrl u_pwr_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .req_ack(req_ack), .req_err(req_err), .wake_touch(wake_touch),
    .wake_timer(wake_timer), .wake_key(wake_key), .wake_call(wake_call),
    .pwr_key(pwr_key), .clk_stable(clk_stable), .clk_sel_slow(clk_sel_slow),
    .core_clk_en(core_clk_en), .kbd_bl_en(kbd_bl_en), .lcd_bl_en(lcd_bl_en),
    .periph_pwr_en(periph_pwr_en), .modem_pwr_en(modem_pwr_en),
    .mode_status(mode_status)
  );

  typedef struct {
    int          cyc;
    logic [9:0]  vec;
    string       tag;
  } exp_t;

  exp_t sb_q[$];
  int   cyc = 0;
  int   n_checks = 0;
  int   n_errs = 0;
  int   m = MN;
  bit   e_err = 1'b0;
  logic [9:0] obs;

  assign obs = {req_ack, req_err, mode_status, modem_pwr_en, periph_pwr_en,
                lcd_bl_en, kbd_bl_en, core_clk_en, clk_sel_slow};

  always @(posedge clk) cyc++;

  // expected outputs from the backlight, supply and clock groups (R2 table)
  function automatic logic [9:0] vec_of(int blm, int perm, int clkm, int st, bit ack, bit err);
    logic [1:0] s;
    s = st[1:0];
    return {ack, err, s, (perm != MO), (perm <= MI), (blm == MN), (blm == MN),
            (clkm == MN), (clkm >= MS)};
  endfunction

  function automatic bit legal(int cur, int t);
    return (cur == MN && t != MN) || (cur == MI && t == MS);
  endfunction

  task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin : monitor
    exp_t e;
    while (sb_q.size() > 0 && sb_q[0].cyc <= cyc) begin
      e = sb_q.pop_front();
      check(e.tag, obs, e.vec);
    end
  end

  task automatic push(input int off, input logic [9:0] v, input string tag);
    exp_t e;
    e.cyc = cyc + off;
    e.vec = v;
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    while (sb_q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic request(input int t, input string tag);
    req_valid = 1'b1;
    req_mode  = t[1:0];
    if (legal(m, t)) begin
      push(1, vec_of(t, m, m, m, 0, e_err), {tag, " R3 lights step"});
      push(2, vec_of(t, t, m, m, 0, e_err), {tag, " R3 supply step"});
      push(3, vec_of(t, t, t, t, 1, e_err), {tag, " R3 clock step ack"});
      push(4, vec_of(t, t, t, t, 0, e_err), {tag, " R2 settled R10"});
      m = t;
    end else begin
      e_err = 1'b1;
      push(1, vec_of(m, m, m, m, 1, 1), {tag, " R4 reject ack"});
      push(2, vec_of(m, m, m, m, 0, 1), {tag, " R4 sticky no change"});
    end
    tick(1);
    req_valid = 1'b0;
    drain();
  endtask

  task automatic idle_wake(input int src, input bit with_req, input string tag);
    case (src)
      0: wake_touch = 1'b1;
      1: wake_timer = 1'b1;
      2: wake_key   = 1'b1;
      default: wake_call = 1'b1;
    endcase
    if (with_req) begin
      req_valid = 1'b1;
      req_mode  = 2'd2;
    end
    push(1, vec_of(MI, MI, MN, MI, 0, e_err), {tag, " R5 clock step"});
    push(2, vec_of(MI, MN, MN, MI, 0, e_err), {tag, " R5 supply step"});
    push(3, vec_of(MN, MN, MN, MN, 0, e_err), {tag, " R5 lights step"});
    push(4, vec_of(MN, MN, MN, MN, 0, e_err), {tag, " R5 R11 settled"});
    tick(1);
    {wake_touch, wake_timer, wake_key, wake_call} = 4'b0;
    req_valid = 1'b0;
    m = MN;
    drain();
  endtask

  task automatic key_press(input int n, input bit wakes, input bit stall, input string tag);
    if (stall) clk_stable = 1'b0;
    pwr_key = 1'b1;
    tick(n);
    pwr_key = 1'b0;
    if (!wakes) begin
      push(6, vec_of(m, m, m, m, 0, e_err), {tag, " R7 ignored"});
      push(9, vec_of(m, m, m, m, 0, e_err), {tag, " R7 ignored later"});
      drain();
    end else begin
      push(4, vec_of(MS, MS, MN, MS, 0, e_err), {tag, " R6 clock step"});
      if (!stall) begin
        push(5, vec_of(MS, MN, MN, MS, 0, e_err), {tag, " R6 supply step"});
        push(6, vec_of(MN, MN, MN, MN, 0, e_err), {tag, " R6 R7 normal"});
        drain();
      end else begin
        push(5, vec_of(MS, MS, MN, MS, 0, e_err), {tag, " R8 stalled"});
        push(6, vec_of(MS, MS, MN, MS, 0, e_err), {tag, " R8 still stalled"});
        tick(6);
        clk_stable = 1'b1;
        push(1, vec_of(MS, MN, MN, MS, 0, e_err), {tag, " R8 supply after stable"});
        push(2, vec_of(MN, MN, MN, MN, 0, e_err), {tag, " R8 normal"});
        drain();
      end
      m = MN;
    end
  endtask

  initial begin : watchdog
    #(4 * 200000);
    n_checks++;
    n_errs++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin : main
    rst_n = 1'b0; req_valid = 1'b0; req_mode = 2'd0; pwr_key = 1'b0;
    wake_touch = 1'b0; wake_timer = 1'b0; wake_key = 1'b0; wake_call = 1'b0;
    clk_stable = 1'b1;
    tick(3);
    check("R1 in reset", obs, vec_of(MN, MN, MN, MN, 0, 0));
    rst_n = 1'b1;
    tick(4);
    check("R1 after release", obs, vec_of(MN, MN, MN, MN, 0, 0));

    // idle entry and each idle wake source
    request(MI, "n2i a");
    idle_wake(0, 0, "touch");
    request(MI, "n2i b");
    idle_wake(1, 0, "timer");
    request(MI, "n2i c");
    idle_wake(2, 0, "key");
    request(MI, "n2i d");
    idle_wake(3, 1, "call+req R11");

    // illegal request from normal, and from idle
    request(MN, "n2n R4");
    request(MI, "n2i e");
    request(MN, "i2n R4");
    idle_wake(0, 0, "touch2");

    // idle to sleep, ignored wakes, press window
    request(MI, "n2i f");
    request(MS, "i2s");
    wake_touch = 1'b1; wake_call = 1'b1; wake_timer = 1'b1; wake_key = 1'b1;
    push(2, vec_of(MS, MS, MS, MS, 0, e_err), "R6 idle wakes ignored in sleep");
    push(4, vec_of(MS, MS, MS, MS, 0, e_err), "R6 idle wakes ignored in sleep later");
    tick(3);
    {wake_touch, wake_timer, wake_key, wake_call} = 4'b0;
    drain();
    request(MI, "s2i R4");
    key_press(3, 0, 0, "press 3 too short");
    key_press(17, 0, 0, "press 17 too long");
    key_press(4, 1, 0, "press 4 min");

    // normal to sleep, max press with clock stall
    request(MS, "n2s");
    key_press(16, 1, 1, "press 16 max");

    // a short press in normal does nothing
    key_press(5, 0, 0, "press in normal");

    // stopped mode
    request(MO, "n2o R10 modem off");
    wake_touch = 1'b1; wake_call = 1'b1;
    push(2, vec_of(MO, MO, MO, MO, 0, e_err), "R9 wakes ignored in off");
    tick(3);
    {wake_touch, wake_call} = 2'b0;
    drain();
    key_press(5, 0, 0, "R9 press in off");
    request(MI, "o2i R9");
    rst_n = 1'b0;
    e_err = 1'b0;
    m = MN;
    tick(1);
    check("R9 R1 reset leaves off", obs, vec_of(MN, MN, MN, MN, 0, 0));
    rst_n = 1'b1;
    tick(4);
    check("R9 R1 normal after reset", obs, vec_of(MN, MN, MN, MN, 0, 0));
    request(MS, "n2s after reset");

    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule